// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Controller

This block holds the interrupt state that the two channels of a dual-channel serial controller share. Each channel sends it a receive-character event, a transmit-buffer-empty event, read and write strobes for its data register, and a command strobe with a 3-bit command code. From these inputs the block keeps a pending bit and an under-service bit for receive and for transmit on each channel. It also keeps a pending-status byte and a modified interrupt vector that records the most recent cause, and it drives one interrupt request line for both channels.

A receive interrupt that is under service holds back a transmit interrupt on the same channel. The deferred transmit interrupt is raised later, when the receive interrupt is cleared or when the highest under-service level is reset. A select input places the vector code in the upper or the lower bit field of the byte. The request line, the status byte and the vector are all registered. Channel index 0 is channel A and index 1 is channel B on every per-channel port.

Top module: `sio_irq_vector`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, pendStatus, intVector and irq are all zero.
- R2: A receive-character event sets the receive pending bit of that channel and puts the receive interrupt under service. It also sets the channel's receive status bit (bit 5 for A, bit 2 for B) and loads that channel's receive vector code.
- R3: The vector codes with statusHigh set are: none 0x60, A receive 0x30, B receive 0x20, A transmit 0x10, B transmit 0x00. With statusHigh clear they are: none 0x06, A receive 0x0C, B receive 0x04, A transmit 0x08, B transmit 0x00. statusHigh is read at the moment a code is loaded.
- R4: A transmit-empty event always sets the transmit pending bit. Only when no receive interrupt of that channel is under service does it enter service and load the transmit vector code. In that case it also sets the transmit status bit (bit 4 for A, bit 1 for B), but only if txIntEnable of the channel is set.
- R5: irq rises one clock after any channel meets one of three conditions: transmit pending with txIntEnable set, receive pending with rxIntMode equal to 01 or 10, or brkIntEnable and brkStatus both high. Otherwise irq is low. rxIntMode 00 and 11 disable receive interrupts.
- R6: A data read clears the channel's receive pending bit, its receive under-service bit and its receive status bit, and loads the no-interrupt code. If a transmit interrupt is still pending, it is then raised again as in R4.
- R7: A data write clears the channel's transmit pending bit. pendStatus and intVector do not change.
- R8: Command code 101 clears the channel's transmit pending bit, its transmit under-service bit and its transmit status bit, and loads the no-interrupt code. If a receive interrupt is still pending, it is then raised again as in R2.
- R9: Command code 111 acts on the highest level under service. If a receive interrupt is under service, the command ends it and raises any pending transmit interrupt as in R4. If not, the command ends transmit service.
- R10: Command codes other than 101 and 111 have no effect.
- R11: Within one channel, events in the same cycle are applied in this order: data read, command, data write, receive event, transmit event. A receive event and a transmit event in the same cycle therefore leave the transmit interrupt deferred.
- R12: When both channels have events in the same cycle, channel B is applied first and channel A last, so the vector shows channel A's cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxCharEv | input | 2 | Receive character available event, one bit per channel |
| txEmptyEv | input | 2 | Transmit buffer empty event, one bit per channel |
| dataRdStb | input | 2 | Data register read strobe, one bit per channel |
| dataWrStb | input | 2 | Data register write strobe, one bit per channel |
| cmdWrStb | input | 2 | Command write strobe, one bit per channel |
| cmdCode | input | 3 | Command code for the channels whose command strobe is high |
| rxIntMode | input | 2x2 | Receive interrupt mode of each channel (01 first char, 10 all chars) |
| txIntEnable | input | 2 | Transmit interrupt enable of each channel |
| brkIntEnable | input | 2 | Break interrupt enable of each channel |
| brkStatus | input | 2 | Break condition status of each channel |
| statusHigh | input | 1 | Places the vector code in the upper bit field when set |
| pendStatus | output | 8 | Pending status: B tx bit 1, B rx bit 2, A tx bit 4, A rx bit 5 |
| intVector | output | 8 | Modified interrupt vector |
| irq | output | 1 | Combined interrupt request |

## Verification
Every event and configuration input is sampled on one rising edge. pendStatus, intVector and irq take their new values on that same edge, so each result is due exactly one clock after its stimulus. The bench drives inputs after a falling edge and reads the outputs at the next falling edge. In this way it always compares the state that the preceding edge produced. One check reads irq before the edge, right after the break inputs change, to confirm that the old value still holds for that cycle.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  localparam int NUM_CH = 2;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 3;
  localparam int MODE_W = 2;

  localparam logic [CMD_W-1:0]  CMD_CLR_TX  = 3'b101;
  localparam logic [CMD_W-1:0]  CMD_RST_IUS = 3'b111;
  localparam logic [MODE_W-1:0] MODE_FIRST  = 2'b01;
  localparam logic [MODE_W-1:0] MODE_ALL    = 2'b10;

  // cause code; low form is code<<1, high form is bit-reversed code<<4
  typedef enum logic [2:0] {
    CAUSE_B_TX = 3'd0,
    CAUSE_B_RX = 3'd2,
    CAUSE_NONE = 3'd3,
    CAUSE_A_TX = 3'd4,
    CAUSE_A_RX = 3'd6
  } cause_e;

  typedef struct packed {
    logic rdClr;
    logic cmdClrTx;
    logic cmdRstIus;
    logic wrClr;
    logic rxSet;
    logic txSet;
  } chStrobe_t;

  typedef struct packed {
    logic rxIntEn;
    logic txIntEn;
    logic brkEn;
    logic brkSeen;
  } chCfg_t;

  typedef struct packed {
    logic [NUM_CH-1:0] rxP;
    logic [NUM_CH-1:0] txP;
    logic [NUM_CH-1:0] rxS;
    logic [NUM_CH-1:0] txS;
    logic [BYTE_W-1:0] stat;
    logic [BYTE_W-1:0] vec;
  } ivcState_t;

  // ch: 0 = channel A, 1 = channel B
  function automatic logic [2:0] statBit(logic ch, logic isRx);
    if (ch) return isRx ? 3'd2 : 3'd1;
    return isRx ? 3'd5 : 3'd4;
  endfunction

  function automatic cause_e causeFor(logic ch, logic isRx);
    if (ch) return isRx ? CAUSE_B_RX : CAUSE_B_TX;
    return isRx ? CAUSE_A_RX : CAUSE_A_TX;
  endfunction

  function automatic logic [BYTE_W-1:0] vecByte(cause_e c, logic hi);
    logic [2:0] v;
    v = c;
    if (hi) return {1'b0, v[0], v[1], v[2], 4'b0000};
    return {4'b0000, v, 1'b0};
  endfunction

  function automatic ivcState_t doSetRx(ivcState_t s, logic ch, logic hi);
    ivcState_t r;
    r = s;
    r.rxP[ch] = 1'b1;
    r.rxS[ch] = 1'b1;
    r.stat[statBit(ch, 1'b1)] = 1'b1;
    r.vec = vecByte(causeFor(ch, 1'b1), hi);
    return r;
  endfunction

  function automatic ivcState_t doSetTx(ivcState_t s, logic ch, logic hi, logic txEn);
    ivcState_t r;
    r = s;
    r.txP[ch] = 1'b1;
    if (!r.rxS[ch]) begin
      r.txS[ch] = 1'b1;
      if (txEn) r.stat[statBit(ch, 1'b0)] = 1'b1;
      r.vec = vecByte(causeFor(ch, 1'b0), hi);
    end
    return r;
  endfunction

  function automatic ivcState_t doClrRx(ivcState_t s, logic ch, logic hi, logic txEn);
    ivcState_t r;
    r = s;
    r.rxP[ch] = 1'b0;
    r.rxS[ch] = 1'b0;
    r.stat[statBit(ch, 1'b1)] = 1'b0;
    r.vec = vecByte(CAUSE_NONE, hi);
    if (r.txP[ch]) r = doSetTx(r, ch, hi, txEn);
    return r;
  endfunction

  function automatic ivcState_t doClrTx(ivcState_t s, logic ch, logic hi);
    ivcState_t r;
    r = s;
    r.txP[ch] = 1'b0;
    r.txS[ch] = 1'b0;
    r.stat[statBit(ch, 1'b0)] = 1'b0;
    r.vec = vecByte(CAUSE_NONE, hi);
    if (r.rxP[ch]) r = doSetRx(r, ch, hi);
    return r;
  endfunction

  function automatic ivcState_t doRstIus(ivcState_t s, logic ch, logic hi, logic txEn);
    ivcState_t r;
    r = s;
    if (r.rxS[ch]) begin
      r.rxS[ch] = 1'b0;
      if (r.txP[ch]) r = doSetTx(r, ch, hi, txEn);
    end else if (r.txS[ch]) begin
      r.txS[ch] = 1'b0;
    end
    return r;
  endfunction

  // per-channel event order: read, command, write, receive, transmit
  function automatic ivcState_t applyChannel(ivcState_t s, logic ch, chStrobe_t st,
                                             logic txEn, logic hi);
    ivcState_t r;
    r = s;
    if (st.rdClr)     r = doClrRx(r, ch, hi, txEn);
    if (st.cmdClrTx)  r = doClrTx(r, ch, hi);
    if (st.cmdRstIus) r = doRstIus(r, ch, hi, txEn);
    if (st.wrClr)     r.txP[ch] = 1'b0;
    if (st.rxSet)     r = doSetRx(r, ch, hi);
    if (st.txSet)     r = doSetTx(r, ch, hi, txEn);
    return r;
  endfunction

endpackage

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
(
  input  logic [NUM_CH-1:0]             rxCharEv,
  input  logic [NUM_CH-1:0]             txEmptyEv,
  input  logic [NUM_CH-1:0]             dataRdStb,
  input  logic [NUM_CH-1:0]             dataWrStb,
  input  logic [NUM_CH-1:0]             cmdWrStb,
  input  logic [CMD_W-1:0]              cmdCode,
  input  logic [NUM_CH-1:0][MODE_W-1:0] rxIntMode,
  input  logic [NUM_CH-1:0]             txIntEnable,
  input  logic [NUM_CH-1:0]             brkIntEnable,
  input  logic [NUM_CH-1:0]             brkStatus,
  input  logic                          statusHigh,
  output chStrobe_t                     strb [NUM_CH],
  output chCfg_t                        cfg  [NUM_CH],
  output logic                          statusHi
);

  logic isClrTx;
  logic isRstIus;

  assign isClrTx  = (cmdCode == CMD_CLR_TX);
  assign isRstIus = (cmdCode == CMD_RST_IUS);
  assign statusHi = statusHigh;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_comb begin
      strb[g].rdClr     = dataRdStb[g];
      strb[g].cmdClrTx  = cmdWrStb[g] && isClrTx;
      strb[g].cmdRstIus = cmdWrStb[g] && isRstIus;
      strb[g].wrClr     = dataWrStb[g];
      strb[g].rxSet     = rxCharEv[g];
      strb[g].txSet     = txEmptyEv[g];

      cfg[g].rxIntEn = (rxIntMode[g] == MODE_FIRST) || (rxIntMode[g] == MODE_ALL);
      cfg[g].txIntEn = txIntEnable[g];
      cfg[g].brkEn   = brkIntEnable[g];
      cfg[g].brkSeen = brkStatus[g];
    end
  end

endmodule

// File: rtl/sio_irq_datapath.sv
module sio_irq_datapath
  import sio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  chStrobe_t         strb [NUM_CH],
  input  chCfg_t            cfg  [NUM_CH],
  input  logic              statusHi,
  output logic [BYTE_W-1:0] pendStatus,
  output logic [BYTE_W-1:0] intVector,
  output logic              irq
);

  ivcState_t         cur;
  ivcState_t         nxt;
  logic              irqQ;
  logic [NUM_CH-1:0] chReq;

  // channel B first, channel A last so A's cause stays in the vector
  always_comb begin
    nxt = cur;
    nxt = applyChannel(nxt, 1'b1, strb[1], cfg[1].txIntEn, statusHi);
    nxt = applyChannel(nxt, 1'b0, strb[0], cfg[0].txIntEn, statusHi);
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_req
    assign chReq[g] = (cfg[g].txIntEn && nxt.txP[g]) ||
                      (cfg[g].rxIntEn && nxt.rxP[g]) ||
                      (cfg[g].brkEn   && cfg[g].brkSeen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cur  <= '0;
      irqQ <= 1'b0;
    end else begin
      cur  <= nxt;
      irqQ <= |chReq;
    end
  end

  assign pendStatus = cur.stat;
  assign intVector  = cur.vec;
  assign irq        = irqQ;

endmodule

// File: rtl/sio_irq_vector.sv
module sio_irq_vector
  import sio_irq_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0]             rxCharEv,
  input  logic [NUM_CH-1:0]             txEmptyEv,
  input  logic [NUM_CH-1:0]             dataRdStb,
  input  logic [NUM_CH-1:0]             dataWrStb,
  input  logic [NUM_CH-1:0]             cmdWrStb,
  input  logic [CMD_W-1:0]              cmdCode,
  input  logic [NUM_CH-1:0][MODE_W-1:0] rxIntMode,
  input  logic [NUM_CH-1:0]             txIntEnable,
  input  logic [NUM_CH-1:0]             brkIntEnable,
  input  logic [NUM_CH-1:0]             brkStatus,
  input  logic                          statusHigh,
  output logic [BYTE_W-1:0]             pendStatus,
  output logic [BYTE_W-1:0]             intVector,
  output logic                          irq
);

  chStrobe_t strb [NUM_CH];
  chCfg_t    cfg  [NUM_CH];
  logic      statusHi;

  sio_irq_ctrl u_ctrl (
    .rxCharEv     (rxCharEv),
    .txEmptyEv    (txEmptyEv),
    .dataRdStb    (dataRdStb),
    .dataWrStb    (dataWrStb),
    .cmdWrStb     (cmdWrStb),
    .cmdCode      (cmdCode),
    .rxIntMode    (rxIntMode),
    .txIntEnable  (txIntEnable),
    .brkIntEnable (brkIntEnable),
    .brkStatus    (brkStatus),
    .statusHigh   (statusHigh),
    .strb         (strb),
    .cfg          (cfg),
    .statusHi     (statusHi)
  );

  sio_irq_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfg        (cfg),
    .statusHi   (statusHi),
    .pendStatus (pendStatus),
    .intVector  (intVector),
    .irq        (irq)
  );

endmodule

// File: rtl/sio_irq_vector_checker.sv
module sio_irq_vector_checker
  import sio_irq_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic [NUM_CH-1:0]             rxCharEv,
  input logic [NUM_CH-1:0]             txEmptyEv,
  input logic [NUM_CH-1:0]             dataRdStb,
  input logic [NUM_CH-1:0]             dataWrStb,
  input logic [NUM_CH-1:0]             cmdWrStb,
  input logic [CMD_W-1:0]              cmdCode,
  input logic [NUM_CH-1:0][MODE_W-1:0] rxIntMode,
  input logic [NUM_CH-1:0]             txIntEnable,
  input logic [NUM_CH-1:0]             brkIntEnable,
  input logic [NUM_CH-1:0]             brkStatus,
  input logic                          statusHigh,
  input logic [BYTE_W-1:0]             pendStatus,
  input logic [BYTE_W-1:0]             intVector,
  input logic                          irq
);

  logic rxOff0, rxOff1, quietCfg, onlyWrite, onlyOtherCmd;

  assign rxOff0   = (rxIntMode[0] != MODE_FIRST) && (rxIntMode[0] != MODE_ALL);
  assign rxOff1   = (rxIntMode[1] != MODE_FIRST) && (rxIntMode[1] != MODE_ALL);
  assign quietCfg = rxOff0 && rxOff1 && (txIntEnable == '0) &&
                    ((brkIntEnable & brkStatus) == '0);
  assign onlyWrite = (dataWrStb != '0) && (rxCharEv == '0) && (txEmptyEv == '0) &&
                     (dataRdStb == '0) && (cmdWrStb == '0);
  assign onlyOtherCmd = (cmdWrStb != '0) && (cmdCode != CMD_CLR_TX) &&
                        (cmdCode != CMD_RST_IUS) && (rxCharEv == '0) &&
                        (txEmptyEv == '0) && (dataRdStb == '0) && (dataWrStb == '0);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pendStatus == '0) && (intVector == '0) && !irq);

  a_r2_rx_sets_status: assert property (@(posedge clk) disable iff (!rstN)
    rxCharEv[1] |=> pendStatus[2]);

  a_r3_rx_vector_a: assert property (@(posedge clk) disable iff (!rstN)
    rxCharEv[0] |=> intVector == ($past(statusHigh) ? 8'h30 : 8'h0C));

  a_r5_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    quietCfg |=> !irq);

  a_r6_read_clears_rx: assert property (@(posedge clk) disable iff (!rstN)
    dataRdStb[0] && !rxCharEv[0] |=> !pendStatus[5]);

  a_r7_write_holds: assert property (@(posedge clk) disable iff (!rstN)
    onlyWrite |=> $stable(intVector) && $stable(pendStatus));

  a_r10_other_cmd: assert property (@(posedge clk) disable iff (!rstN)
    onlyOtherCmd |=> $stable(intVector) && $stable(pendStatus));

endmodule

bind sio_irq_vector sio_irq_vector_checker u_chk (.*);

// File: tb/sio_irq_vector_bench.sv
`timescale 1ns/1ps
module sio_irq_vector_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] rxCharEv = '0, txEmptyEv = '0, dataRdStb = '0, dataWrStb = '0, cmdWrStb = '0;
  logic [2:0] cmdCode = '0;
  logic [1:0][1:0] rxIntMode = '0;
  logic [1:0] txIntEnable = '0, brkIntEnable = '0, brkStatus = '0;
  logic statusHigh = 1'b0;
  logic [7:0] pendStatus, intVector;
  logic irq;

  int nChecks = 0;
  int nErr = 0;

  always #4 clk = ~clk;

  sio_irq_vector u_sio_irq_vector (
    .clk(clk), .rstN(rstN), .rxCharEv(rxCharEv), .txEmptyEv(txEmptyEv),
    .dataRdStb(dataRdStb), .dataWrStb(dataWrStb), .cmdWrStb(cmdWrStb),
    .cmdCode(cmdCode), .rxIntMode(rxIntMode), .txIntEnable(txIntEnable),
    .brkIntEnable(brkIntEnable), .brkStatus(brkStatus), .statusHigh(statusHigh),
    .pendStatus(pendStatus), .intVector(intVector), .irq(irq)
  );

  // reference model, index 0 = channel A
  bit mRxP[2], mTxP[2], mRxS[2], mTxS[2];
  logic [7:0] mStat = '0, mVec = '0;
  bit mIrq = 0;

  // cause: 0 none, 1 A rx, 2 B rx, 3 A tx, 4 B tx
  function automatic logic [7:0] codeVal(int cause, bit hi);
    case (cause)
      1: return hi ? 8'h30 : 8'h0C;
      2: return hi ? 8'h20 : 8'h04;
      3: return hi ? 8'h10 : 8'h08;
      4: return 8'h00;
      default: return hi ? 8'h60 : 8'h06;
    endcase
  endfunction

  task automatic mSetRx(int c);
    mRxP[c] = 1; mRxS[c] = 1;
    mStat[c == 0 ? 5 : 2] = 1'b1;
    mVec = codeVal(c == 0 ? 1 : 2, statusHigh);
  endtask

  task automatic mSetTx(int c);
    mTxP[c] = 1;
    if (!mRxS[c]) begin
      mTxS[c] = 1;
      if (txIntEnable[c]) mStat[c == 0 ? 4 : 1] = 1'b1;
      mVec = codeVal(c == 0 ? 3 : 4, statusHigh);
    end
  endtask

  task automatic mClrRx(int c);
    mRxP[c] = 0; mRxS[c] = 0;
    mStat[c == 0 ? 5 : 2] = 1'b0;
    mVec = codeVal(0, statusHigh);
    if (mTxP[c]) mSetTx(c);
  endtask

  task automatic mClrTx(int c);
    mTxP[c] = 0; mTxS[c] = 0;
    mStat[c == 0 ? 4 : 1] = 1'b0;
    mVec = codeVal(0, statusHigh);
    if (mRxP[c]) mSetRx(c);
  endtask

  task automatic mRstIus(int c);
    if (mRxS[c]) begin
      mRxS[c] = 0;
      if (mTxP[c]) mSetTx(c);
    end else if (mTxS[c]) begin
      mTxS[c] = 0;
    end
  endtask

  task automatic modelStep();
    if (!rstN) begin
      for (int c = 0; c < 2; c++) begin
        mRxP[c] = 0; mTxP[c] = 0; mRxS[c] = 0; mTxS[c] = 0;
      end
      mStat = '0; mVec = '0; mIrq = 0;
    end else begin
      for (int c = 1; c >= 0; c--) begin
        if (dataRdStb[c]) mClrRx(c);
        if (cmdWrStb[c] && cmdCode == 3'b101) mClrTx(c);
        if (cmdWrStb[c] && cmdCode == 3'b111) mRstIus(c);
        if (dataWrStb[c]) mTxP[c] = 0;
        if (rxCharEv[c]) mSetRx(c);
        if (txEmptyEv[c]) mSetTx(c);
      end
      mIrq = 0;
      for (int c = 0; c < 2; c++) begin
        if ((txIntEnable[c] && mTxP[c]) ||
            ((rxIntMode[c] == 2'b01 || rxIntMode[c] == 2'b10) && mRxP[c]) ||
            (brkIntEnable[c] && brkStatus[c])) mIrq = 1;
      end
    end
  endtask

  task automatic cycle();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    rxCharEv = '0; txEmptyEv = '0; dataRdStb = '0; dataWrStb = '0; cmdWrStb = '0;
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chkOut(string tag, logic [7:0] st, logic [7:0] vc, bit ir);
    chk(tag, pendStatus, st);
    chk(tag, intVector, vc);
    chk(tag, {7'b0, irq}, {7'b0, ir});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    rxIntMode = {2'b10, 2'b10};
    txIntEnable = 2'b11;
    cycle(); cycle();
    chkOut("R1 reset", 8'h00, 8'h00, 0);
    rstN = 1'b1;
    cycle();
    chkOut("R1 after reset", 8'h00, 8'h00, 0);

    rxCharEv = 2'b01; cycle();
    chkOut("R2 A rx", 8'h20, 8'h0C, 1);
    txEmptyEv = 2'b01; cycle();
    chkOut("R4 A tx deferred", 8'h20, 8'h0C, 1);
    dataRdStb = 2'b01; cycle();
    chkOut("R6 read re-raises tx", 8'h10, 8'h08, 1);
    cmdWrStb = 2'b01; cmdCode = 3'b101; cycle();
    chkOut("R8 clear tx", 8'h00, 8'h06, 0);

    statusHigh = 1'b1;
    rxCharEv = 2'b10; cycle();
    chkOut("R3 B rx high", 8'h04, 8'h20, 1);
    txEmptyEv = 2'b01; cycle();
    chkOut("R4 A tx high", 8'h14, 8'h10, 1);
    dataWrStb = 2'b01; cycle();
    chkOut("R7 write", 8'h14, 8'h10, 1);
    cmdWrStb = 2'b10; cmdCode = 3'b111; cycle();
    chkOut("R9 reset rx service", 8'h14, 8'h10, 1);
    txEmptyEv = 2'b10; cycle();
    chkOut("R9 B tx enters service", 8'h16, 8'h00, 1);
    for (int k = 0; k < 8; k++) begin
      if (k != 5 && k != 7) begin
        cmdWrStb = 2'b11; cmdCode = 3'(k); cycle();
        chkOut("R10 other command", 8'h16, 8'h00, 1);
      end
    end
    dataRdStb = 2'b10; cycle();
    chkOut("R6 B read re-raises tx", 8'h12, 8'h00, 1);
    cmdWrStb = 2'b10; cmdCode = 3'b101; cycle();
    chkOut("R8 B clear tx", 8'h10, 8'h60, 0);
    cmdWrStb = 2'b01; cmdCode = 3'b101; cycle();
    chkOut("R8 A clear tx", 8'h00, 8'h60, 0);

    statusHigh = 1'b0;
    rxCharEv = 2'b01; txEmptyEv = 2'b01; cycle();
    chkOut("R11 rx before tx", 8'h20, 8'h0C, 1);
    dataRdStb = 2'b01; cycle();
    chkOut("R11 deferred tx raised", 8'h10, 8'h08, 1);
    cmdWrStb = 2'b01; cmdCode = 3'b101; cycle();
    chkOut("R8 clear", 8'h00, 8'h06, 0);
    rxCharEv = 2'b11; cycle();
    chkOut("R12 A applied last", 8'h24, 8'h0C, 1);

    rxIntMode = {2'b00, 2'b00}; cycle();
    chk("R5 mode 00", {7'b0, irq}, 8'h00);
    rxIntMode = {2'b11, 2'b11}; cycle();
    chk("R5 mode 11", {7'b0, irq}, 8'h00);
    rxIntMode = {2'b01, 2'b01}; cycle();
    chk("R5 mode 01", {7'b0, irq}, 8'h01);
    rxIntMode = {2'b10, 2'b10};
    dataRdStb = 2'b11; cycle();
    chkOut("R6 both read", 8'h00, 8'h06, 0);
    brkIntEnable = 2'b01; brkStatus = 2'b01;
    #1 chk("R5 irq not before edge", {7'b0, irq}, 8'h00);
    cycle();
    chk("R5 break irq", {7'b0, irq}, 8'h01);
    brkIntEnable = 2'b00; cycle();
    chk("R5 break disabled", {7'b0, irq}, 8'h00);
    brkStatus = 2'b00;
    txIntEnable = 2'b10;
    txEmptyEv = 2'b01; cycle();
    chkOut("R4 tx disabled", 8'h00, 8'h08, 0);
    cmdWrStb = 2'b01; cmdCode = 3'b101; cycle();
    chkOut("R8 clear", 8'h00, 8'h06, 0);
    txIntEnable = 2'b11;

    repeat (4000) begin
      rstN = ($urandom_range(199) != 0);
      rxCharEv  = 2'($urandom_range(3) == 0) | (2'($urandom_range(3) == 0) << 1);
      txEmptyEv = 2'($urandom_range(3) == 0) | (2'($urandom_range(3) == 0) << 1);
      dataRdStb = 2'($urandom_range(3) == 0) | (2'($urandom_range(3) == 0) << 1);
      dataWrStb = 2'($urandom_range(4) == 0) | (2'($urandom_range(4) == 0) << 1);
      cmdWrStb  = 2'($urandom_range(3) == 0) | (2'($urandom_range(3) == 0) << 1);
      cmdCode   = 3'($urandom_range(7));
      if ($urandom_range(15) == 0) begin
        rxIntMode    = 4'($urandom_range(15));
        txIntEnable  = 2'($urandom_range(3));
        brkIntEnable = 2'($urandom_range(3));
        statusHigh   = 1'($urandom_range(1));
      end
      brkStatus = 2'($urandom_range(3));
      cycle();
      chk("R2 sweep status", pendStatus, mStat);
      chk("R3 sweep vector", intVector, mVec);
      chk("R5 sweep irq", {7'b0, irq}, {7'b0, mIrq});
    end

    rstN = 1'b0; cycle();
    chkOut("R1 final reset", 8'h00, 8'h00, 0);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule